// File: doc/BRIEF.md
# Two-Bank 16-Bit Byte-Laned Memory

This block is a 16-bit wide memory made of two byte-wide banks. The even bytes of every word live in the low bank, which carries data bits 7..0. The odd bytes live in the high bank, which carries data bits 15..8. A requester presents a byte address, a pair of active-low lane enables (one for the high bank, one for the low bank), active-low read and write commands and a memory/IO qualifier. The block decodes its own address window from the upper address bits. It passes the word index, taken from address bit 1 upward, to both banks. It forms a separate write strobe for each bank.

Address bit 0 never reaches the banks. A word write uses both enables, and a byte write uses one enable. On a read, both banks always drive the full word. The requester picks the byte it wants from that word.

Each bank is a synchronous array of registers. A write lands on the clock edge. A read is combinational from the addressed word.

Top module: `dual_bank_mem16`

## Requirements
- R1: With the high enable low and the low enable low, a selected write stores wdata[15:8] in the high bank and wdata[7:0] in the low bank at the addressed word.
- R2: With the high enable low and the low enable high, a selected write stores only wdata[15:8], and the low byte of that word keeps its previous value.
- R3: With the high enable high and the low enable low, a selected write stores only wdata[7:0], and the high byte keeps its previous value.
- R4: With both enables high, no byte of any word changes.
- R5: The word index is addr[IDX_W:1], and addr[0] has no effect: two addresses that differ only in bit 0 reach the same word.
- R6: No write happens while the write command (active low) is high.
- R7: The block is selected only when the memory/IO qualifier is 1 (memory) and addr[ADDR_W-1:IDX_W+1] equals REGION_BASE. When it is not selected, no bank is written.
- R8: While the block is selected and the read command is low, rdata is {high byte, low byte} of the addressed word in the same cycle, whatever the enables are.
- R9: rdata is zero whenever the block is not selected or the read command is high.
- R10: A clock edge with rst_n low clears every word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, clears the banks |
| addr | input | ADDR_W | Byte address |
| hi_en_n | input | 1 | Active-low enable for the odd-byte (high) bank |
| lo_en_n | input | 1 | Active-low enable for the even-byte (low) bank |
| rd_cmd_n | input | 1 | Active-low memory read command |
| wr_cmd_n | input | 1 | Active-low memory write command |
| mem_sel | input | 1 | 1 for a memory cycle, 0 for an IO cycle |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero when not reading this block |

## Verification
The bench builds the block with ADDR_W=8, IDX_W=3 and REGION_BASE=5. This gives 8 words per bank and a 4-bit region field, so the whole 256-byte address space can be swept. The sweep reaches every out-of-window address and both values of bit 0 at every word. Every word is also written under each of the four enable combinations, and the result is compared with an arithmetic model. Further checks cover the IO qualifier, an inactive write command and an inactive read command.

// File: rtl/mem16_pkg.sv
// Package: shared constants for the two-bank memory.
// Assumes lane 0 is the even-byte bank and lane 1 is the odd-byte bank.
package mem16_pkg;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = 2;
    localparam int WORD_W    = LANE_W * NUM_LANES;
    localparam int LANE_LO   = 0;
    localparam int LANE_HI   = 1;
endpackage

// File: rtl/region_decode.sv
// Module: region_decode
// Decodes whether a cycle targets this memory, and extracts the word index.
// Assumes byte addressing: bit 0 picks a lane and is never used as an index bit.
module region_decode #(
    parameter int ADDR_W      = 16,
    parameter int IDX_W       = 7,
    parameter int REGION_BASE = 'h3C
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_sel,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int REG_W = ADDR_W - IDX_W - 1;

    logic [REG_W-1:0] region_field;

    // Separate the region field and the word index from the byte address
    always_comb begin
        region_field = addr[ADDR_W-1:IDX_W+1];
        idx          = addr[IDX_W:1];
    end

    // Select only for memory cycles whose upper bits match the window
    always_comb begin
        hit = mem_sel && (region_field == REG_W'(REGION_BASE));
    end
endmodule

// File: rtl/lane_strobe.sv
// Module: lane_strobe
// Forms one write strobe per byte lane from the write command and the lane enables.
// Assumes all enables and the command are active low, and hit is active high.
module lane_strobe #(
    parameter int NUM_LANES = 2
) (
    input  logic [NUM_LANES-1:0] en_n,
    input  logic                 wr_cmd_n,
    input  logic                 hit,
    output logic [NUM_LANES-1:0] stb
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        // Strobe this lane when it is enabled during a selected write
        always_comb begin
            stb[g] = hit && !wr_cmd_n && !en_n[g];
        end
    end
endmodule

// File: rtl/byte_bank.sv
// Module: byte_bank
// One byte-wide bank: synchronous write on the strobe, combinational read.
// Assumes a synchronous active-low reset that clears every entry.
module byte_bank #(
    parameter int DEPTH = 128,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [W-1:0]             wd,
    output logic [W-1:0]             rd
);
    logic [W-1:0] mem [DEPTH];

    // Clear on reset, otherwise store the byte at the index when strobed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wd;
        end
    end

    // Present the addressed byte without waiting for a clock
    always_comb begin
        rd = mem[idx];
    end

    // R1
    stored_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(idx)] == $past(wd));

    // R4
    unstrobed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> mem[$past(idx)] == $past(rd));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> rd == '0);
endmodule

// File: rtl/dual_bank_mem16.sv
// Module: dual_bank_mem16
// A 16-bit memory built from an even-byte bank and an odd-byte bank.
// Assumes aligned accesses only; a word that straddles two rows is not split.
module dual_bank_mem16
    import mem16_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int IDX_W       = 7,
    parameter int REGION_BASE = 'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              hi_en_n,
    input  logic              lo_en_n,
    input  logic              rd_cmd_n,
    input  logic              wr_cmd_n,
    input  logic              mem_sel,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic                  hit;
    logic [IDX_W-1:0]      idx;
    logic [NUM_LANES-1:0]  en_n;
    logic [NUM_LANES-1:0]  stb;
    logic [WORD_W-1:0]     word;

    // Gather the lane enables in lane order
    always_comb begin
        en_n          = '1;
        en_n[LANE_LO] = lo_en_n;
        en_n[LANE_HI] = hi_en_n;
    end

    region_decode #(
        .ADDR_W      (ADDR_W),
        .IDX_W       (IDX_W),
        .REGION_BASE (REGION_BASE)
    ) u_dec (
        .addr    (addr),
        .mem_sel (mem_sel),
        .hit     (hit),
        .idx     (idx)
    );

    lane_strobe #(
        .NUM_LANES (NUM_LANES)
    ) u_stb (
        .en_n     (en_n),
        .wr_cmd_n (wr_cmd_n),
        .hit      (hit),
        .stb      (stb)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_bank
        byte_bank #(
            .DEPTH (DEPTH),
            .W     (LANE_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (stb[g]),
            .idx   (idx),
            .wd    (wdata[g*LANE_W +: LANE_W]),
            .rd    (word[g*LANE_W +: LANE_W])
        );
    end

    // Drive the word only during a selected read, otherwise hold the bus at zero
    always_comb begin
        rdata = (hit && !rd_cmd_n) ? word : '0;
    end

    // R4
    no_lane_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_en_n && lo_en_n) |-> stb == '0);

    // R7
    io_cycle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_sel |-> stb == '0);

    // R6
    no_command_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd_n |-> stb == '0);

    // R9
    io_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel || rd_cmd_n) |-> rdata == '0);
endmodule

// File: tb/tb_dual_bank_mem16.sv
module tb_dual_bank_mem16;
    localparam int AW   = 8;
    localparam int IW   = 3;
    localparam int BASE = 5;
    localparam int NW   = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          hi_en_n, lo_en_n, rd_cmd_n, wr_cmd_n, mem_sel;
    logic [15:0]   wdata;
    logic [15:0]   rdata;

    logic [15:0]   model [NW];
    int            total = 0;
    int            bad   = 0;
    bit            done  = 1'b0;

    always #5 clk = ~clk;

    dual_bank_mem16 #(.ADDR_W(AW), .IDX_W(IW), .REGION_BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n),
        .rd_cmd_n(rd_cmd_n), .wr_cmd_n(wr_cmd_n), .mem_sel(mem_sel),
        .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [AW-1:0] in_addr(input int w, input bit b0);
        return AW'((BASE << (IW + 1)) | (w << 1) | int'(b0));
    endfunction

    task automatic do_write(input logic [AW-1:0] a, input bit hn, input bit ln,
                            input bit ms, input logic [15:0] d);
        @(negedge clk);
        addr = a; hi_en_n = hn; lo_en_n = ln; mem_sel = ms; wdata = d;
        rd_cmd_n = 1'b1; wr_cmd_n = 1'b0;
        @(negedge clk);
        wr_cmd_n = 1'b1; hi_en_n = 1'b1; lo_en_n = 1'b1;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input bit ms, input bit rn,
                           input bit hn, input bit ln, output logic [15:0] v);
        @(negedge clk);
        addr = a; mem_sel = ms; rd_cmd_n = rn; wr_cmd_n = 1'b1;
        hi_en_n = hn; lo_en_n = ln;
        #1 v = rdata;
        rd_cmd_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        rst_n = 1'b0; addr = '0; hi_en_n = 1'b1; lo_en_n = 1'b1;
        rd_cmd_n = 1'b1; wr_cmd_n = 1'b1; mem_sel = 1'b1; wdata = '0;
        for (int i = 0; i < NW; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset leaves every word at zero
        for (int w = 0; w < NW; w++) begin
            do_read(in_addr(w, 0), 1'b1, 1'b0, 1'b0, 1'b0, v);
            check("R10 reset word", v, 16'h0000);
        end

        // R1 R2 R3 R4: every enable pair on every word
        for (int w = 0; w < NW; w++) begin
            for (int c = 0; c < 4; c++) begin
                logic [15:0] d;
                d = 16'((w * 4 + c + 1) * 16'h1357);
                do_write(in_addr(w, c[0]), c[1], c[0], 1'b1, d);
                if (!c[1]) model[w][15:8] = d[15:8];
                if (!c[0]) model[w][7:0]  = d[7:0];
                do_read(in_addr(w, 0), 1'b1, 1'b0, 1'b1, 1'b1, v);
                case (c)
                    0: check("R1 word write", v, model[w]);
                    1: check("R2 high-only write", v, model[w]);
                    2: check("R3 low-only write", v, model[w]);
                    default: check("R4 no-lane write", v, model[w]);
                endcase
                // R5: bit 0 reaches the same word
                do_read(in_addr(w, 1), 1'b1, 1'b0, 1'b0, 1'b1, v);
                check("R5 odd address same word", v, model[w]);
            end
        end

        // R7 R9 R5: sweep the whole address space with word writes
        for (int a = 0; a < (1 << AW); a++) begin
            logic [15:0] d;
            bit          inr;
            d   = {8'(a), ~8'(a)};
            inr = ((a >> (IW + 1)) == BASE);
            do_write(AW'(a), 1'b0, 1'b0, 1'b1, d);
            if (inr) model[(a >> 1) & (NW - 1)] = d;
            do_read(AW'(a), 1'b1, 1'b0, 1'b0, 1'b0, v);
            check(inr ? "R8 selected read" : "R9 out-of-window read", v,
                  inr ? model[(a >> 1) & (NW - 1)] : 16'h0000);
            do_read(in_addr((a >> 1) & (NW - 1), 0), 1'b1, 1'b0, 1'b0, 1'b0, v);
            check("R7 window decode", v, model[(a >> 1) & (NW - 1)]);
        end

        // R7: an IO cycle writes nothing and reads zero
        do_write(in_addr(2, 0), 1'b0, 1'b0, 1'b0, 16'hDEAD);
        do_read(in_addr(2, 0), 1'b0, 1'b0, 1'b0, 1'b0, v);
        check("R7 io read zero", v, 16'h0000);
        do_read(in_addr(2, 0), 1'b1, 1'b0, 1'b0, 1'b0, v);
        check("R7 io write ignored", v, model[2]);

        // R6: enables without the write command change nothing
        @(negedge clk);
        addr = in_addr(3, 0); hi_en_n = 1'b0; lo_en_n = 1'b0; mem_sel = 1'b1;
        wdata = 16'hBEEF; wr_cmd_n = 1'b1; rd_cmd_n = 1'b1;
        repeat (2) @(negedge clk);
        do_read(in_addr(3, 0), 1'b1, 1'b0, 1'b1, 1'b1, v);
        check("R6 no command no write", v, model[3]);

        // R9: read command high gives zero on a selected address
        do_read(in_addr(3, 0), 1'b1, 1'b1, 1'b0, 1'b0, v);
        check("R9 no read command", v, 16'h0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule